// File: doc/BRIEF.md
# Multi-port packet bus ingress decoder

This block receives transmit traffic from a link layer over a 32-bit packet bus shared by four ports. It sits on the PHY side and runs on the transmit FIFO clock. The link layer first raises a select strobe with a port number in the low bits of the data bus. After that it sends packet words, each qualified by an active-low enable. A start flag marks the first word of a packet and an end flag marks the last. On the last word a two-bit modulo field gives how many bytes of that word are valid. Parity and an error flag travel with the data.

The decoder turns this bus activity into a registered stream of words. Each word is tagged with its port number, its start and end flags, its count of valid bytes and an errored-packet flag. Each port keeps its own packet-open state. The link layer can therefore switch ports in the middle of a packet and come back later to finish it. A word that arrives on a port with no open packet and no start flag is dropped and reported. A parity mismatch sets a sticky error bit for the port concerned.

Top module: `pktbus_ingress`

## Requirements
- R1: While reset is held and afterwards with no bus activity, `out_vld_o`, `proto_err_o` and every bit of `par_err_o` read 0.
- R2: A cycle with `sel_i` high loads `dat_i[1:0]` as the current port. It produces no output word and no protocol error.
- R3: A cycle with `sel_i` low, `en_n_i` low and `sop_i` high opens a packet on the current port. One clock later it presents the word with `out_vld_o`=1, `out_sop_o`=1, the port on `out_port_o` and the data on `out_dat_o`.
- R4: A cycle with `en_n_i` high and `sel_i` low transfers nothing and produces no output word. The open packet survives it, and the next enabled word without `sop_i` is still accepted.
- R5: An enabled word without `sop_i`, on a port with no open packet, is dropped. One clock later `proto_err_o` pulses for one cycle and `out_vld_o` stays 0.
- R6: On an accepted word with `eop_i` high, `out_cnt_o` is 4 for `mod_i`=00, 3 for 01, 2 for 10 and 1 for 11. `out_eop_o` is 1 and the port's packet is closed.
- R7: Valid bytes fill from bits 31:24 downward. Byte lanes of the final word beyond the count are output as zero.
- R8: Every accepted word without `eop_i` reports `out_cnt_o`=4, `out_eop_o`=0 and `out_err_o`=0.
- R9: `err_i` is sampled only with `eop_i`. `out_err_o` on the final word equals `err_i`, and `err_i` on other words has no effect.
- R10: Parity is odd over `dat_i` and `par_i`. It is checked on cycles with `en_n_i` low or `sel_i` high. A mismatch sets `par_err_o[p]` until reset, where p is the addressed port on select cycles and the current port otherwise. Paused cycles are not checked.
- R11: Packet-open state is kept per port. A packet left open on one port can be resumed without `sop_i` after other ports have been selected and used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit FIFO clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Port-select strobe; data bus carries the port number |
| en_n_i | input | 1 | Active-low word enable |
| sop_i | input | 1 | Start of packet |
| eop_i | input | 1 | End of packet |
| mod_i | input | 2 | Invalid byte count of final word |
| err_i | input | 1 | Packet error, sampled with `eop_i` |
| par_i | input | 1 | Odd parity over `dat_i` |
| dat_i | input | 32 | Data bus |
| out_vld_o | output | 1 | Output word valid |
| out_port_o | output | 2 | Port of the output word |
| out_sop_o | output | 1 | Output word starts a packet |
| out_eop_o | output | 1 | Output word ends a packet |
| out_cnt_o | output | 3 | Valid bytes in output word (1 to 4) |
| out_err_o | output | 1 | Errored packet, on final word only |
| out_dat_o | output | 32 | Output data, unused lanes zeroed |
| proto_err_o | output | 1 | Pulse: word dropped for missing start |
| par_err_o | output | 4 | Sticky parity error per port |

## Verification
Every result is registered once. Output words, the protocol-error pulse and a new parity-error bit all appear one clock after the edge that samples the bus cycle causing them. A select cycle changes the port used from the next cycle on. The bench drives each bus cycle on a falling edge, waits for the following rising edge, and samples a moment later. Each check therefore looks at the response to exactly the cycle just driven. Sticky parity bits are tracked in a bench-side expected vector and compared after each parity stimulus and after the idle cycles that follow it.

// File: rtl/pkb_pkg.sv
package pkb_pkg;
  localparam int DATA_W = 32;
  localparam int PORTS  = 4;
  localparam int BYTES  = DATA_W / 8;
  localparam int PORT_W = $clog2(PORTS);
  localparam int MOD_W  = $clog2(BYTES);
  localparam int CNT_W  = $clog2(BYTES + 1);
endpackage

// File: rtl/pkb_port_sel.sv
module pkb_port_sel
  import pkb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [PORT_W-1:0] addr,
  output logic [PORT_W-1:0] port_q
);
  logic [PORT_W-1:0] port_d;

  always_comb begin
    port_d = port_q;
    if (sel) port_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_q <= '0;
    else        port_q <= port_d;
  end
endmodule

// File: rtl/pkb_frame_track.sv
module pkb_frame_track
  import pkb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic              sop,
  input  logic              eop,
  input  logic [PORT_W-1:0] port,
  output logic              accept,
  output logic              drop
);
  logic [PORTS-1:0] open_q;
  logic [PORTS-1:0] open_d;

  always_comb begin
    accept = xfer & (sop | open_q[port]);
    drop   = xfer & ~sop & ~open_q[port];
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_comb begin
      open_d[p] = open_q[p];
      if (accept && (port == PORT_W'(p))) open_d[p] = ~eop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q[p] <= 1'b0;
      else        open_q[p] <= open_d[p];
    end
  end
endmodule

// File: rtl/pkb_par_check.sv
module pkb_par_check
  import pkb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic [DATA_W-1:0] dat,
  input  logic              par,
  input  logic [PORT_W-1:0] port,
  output logic [PORTS-1:0]  err_q
);
  logic             bad;
  logic [PORTS-1:0] err_d;

  always_comb bad = chk_en & ~(^{dat, par});

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_comb err_d[p] = err_q[p] | (bad & (port == PORT_W'(p)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q[p] <= 1'b0;
      else        err_q[p] <= err_d[p];
    end
  end
endmodule

// File: rtl/pkb_out_fmt.sv
module pkb_out_fmt
  import pkb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              drop,
  input  logic [PORT_W-1:0] port,
  input  logic              sop,
  input  logic              eop,
  input  logic [MOD_W-1:0]  md,
  input  logic              err,
  input  logic [DATA_W-1:0] dat,
  output logic              vld_q,
  output logic [PORT_W-1:0] port_q,
  output logic              sop_q,
  output logic              eop_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              err_q,
  output logic [DATA_W-1:0] dat_q,
  output logic              proto_q
);
  logic [CNT_W-1:0]  cnt_d;
  logic [DATA_W-1:0] dat_d;
  logic [PORT_W-1:0] port_d;
  logic              sop_d, eop_d, err_d;

  always_comb begin
    cnt_d = eop ? (CNT_W'(BYTES) - CNT_W'(md)) : CNT_W'(BYTES);
  end

  // lane k counts from the most significant byte
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * k;
    always_comb dat_d[HI -: 8] = (CNT_W'(k) < cnt_d) ? dat[HI -: 8] : 8'h00;
  end

  always_comb begin
    port_d = accept ? port : '0;
    sop_d  = accept & sop;
    eop_d  = accept & eop;
    err_d  = accept & eop & err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      port_q  <= '0;
      sop_q   <= 1'b0;
      eop_q   <= 1'b0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      proto_q <= 1'b0;
    end else begin
      vld_q   <= accept;
      port_q  <= port_d;
      sop_q   <= sop_d;
      eop_q   <= eop_d;
      cnt_q   <= accept ? cnt_d : '0;
      err_q   <= err_d;
      proto_q <= drop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (accept) dat_q <= dat_d;
  end
endmodule

// File: rtl/pktbus_ingress.sv
module pktbus_ingress
  import pkb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              en_n_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [MOD_W-1:0]  mod_i,
  input  logic              err_i,
  input  logic              par_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              out_vld_o,
  output logic [PORT_W-1:0] out_port_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [CNT_W-1:0]  out_cnt_o,
  output logic              out_err_o,
  output logic [DATA_W-1:0] out_dat_o,
  output logic              proto_err_o,
  output logic [PORTS-1:0]  par_err_o
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [PORT_W-1:0] cur_port;
  logic [PORT_W-1:0] chk_port;
  logic              xfer, chk_en, accept, drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  always_comb rst_int_n = rst_pipe[1];

  always_comb begin
    xfer     = ~sel_i & ~en_n_i;
    chk_en   = sel_i | ~en_n_i;
    chk_port = sel_i ? dat_i[PORT_W-1:0] : cur_port;
  end

  pkb_port_sel i_sel (
    .clk(clk), .rst_n(rst_int_n), .sel(sel_i),
    .addr(dat_i[PORT_W-1:0]), .port_q(cur_port)
  );

  pkb_frame_track i_trk (
    .clk(clk), .rst_n(rst_int_n), .xfer(xfer), .sop(sop_i), .eop(eop_i),
    .port(cur_port), .accept(accept), .drop(drop)
  );

  pkb_par_check i_par (
    .clk(clk), .rst_n(rst_int_n), .chk_en(chk_en), .dat(dat_i), .par(par_i),
    .port(chk_port), .err_q(par_err_o)
  );

  pkb_out_fmt i_fmt (
    .clk(clk), .rst_n(rst_int_n), .accept(accept), .drop(drop),
    .port(cur_port), .sop(sop_i), .eop(eop_i), .md(mod_i), .err(err_i),
    .dat(dat_i), .vld_q(out_vld_o), .port_q(out_port_o), .sop_q(out_sop_o),
    .eop_q(out_eop_o), .cnt_q(out_cnt_o), .err_q(out_err_o),
    .dat_q(out_dat_o), .proto_q(proto_err_o)
  );
endmodule

// File: rtl/pkb_checker.sv
module pkb_checker
  import pkb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sel_i,
  input logic             en_n_i,
  input logic             out_vld_o,
  input logic             out_eop_o,
  input logic [CNT_W-1:0] out_cnt_o,
  input logic             out_err_o,
  input logic             proto_err_o,
  input logic [PORTS-1:0] par_err_o
);
  assert_select_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i |=> (!out_vld_o && !proto_err_o));

  assert_pause_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n_i && !sel_i) |=> !out_vld_o);

  assert_drop_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(proto_err_o && out_vld_o));

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_o |-> (out_cnt_o >= CNT_W'(1) && out_cnt_o <= CNT_W'(BYTES)));

  assert_mid_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_o && !out_eop_o) |-> (out_cnt_o == CNT_W'(BYTES)));

  assert_err_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_err_o |-> (out_vld_o && out_eop_o));

  assert_par_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((par_err_o & $past(par_err_o)) == $past(par_err_o)));
endmodule

bind pktbus_ingress pkb_checker i_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .en_n_i(en_n_i),
  .out_vld_o(out_vld_o), .out_eop_o(out_eop_o), .out_cnt_o(out_cnt_o),
  .out_err_o(out_err_o), .proto_err_o(proto_err_o), .par_err_o(par_err_o)
);

// File: tb/test_pktbus_ingress.sv
`timescale 1ns/1ps
module test_pktbus_ingress;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_i, en_n_i, sop_i, eop_i, err_i, par_i;
  logic [1:0]  mod_i;
  logic [31:0] dat_i;
  logic        out_vld_o, out_sop_o, out_eop_o, out_err_o, proto_err_o;
  logic [1:0]  out_port_o;
  logic [2:0]  out_cnt_o;
  logic [31:0] out_dat_o;
  logic [3:0]  par_err_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [3:0] exp_par = 4'b0;

  always #2.5 clk = ~clk;

  pktbus_ingress i_pktbus_ingress (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .en_n_i(en_n_i), .sop_i(sop_i),
    .eop_i(eop_i), .mod_i(mod_i), .err_i(err_i), .par_i(par_i), .dat_i(dat_i),
    .out_vld_o(out_vld_o), .out_port_o(out_port_o), .out_sop_o(out_sop_o),
    .out_eop_o(out_eop_o), .out_cnt_o(out_cnt_o), .out_err_o(out_err_o),
    .out_dat_o(out_dat_o), .proto_err_o(proto_err_o), .par_err_o(par_err_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle: drive on falling edge, sample just after the next rising edge
  task automatic cyc(input logic sel, input logic en_n, input logic sop, input logic eop,
                     input logic [1:0] md, input logic err, input logic [31:0] d,
                     input logic badpar);
    @(negedge clk);
    sel_i = sel; en_n_i = en_n; sop_i = sop; eop_i = eop;
    mod_i = md; err_i = err; dat_i = d;
    par_i = (~^d) ^ badpar;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic expect_word(input string req, input logic [1:0] p, input logic s,
                             input logic e, input int nb, input logic er,
                             input logic [31:0] d);
    logic [31:0] mask;
    mask = 32'hFFFF_FFFF << (8 * (4 - nb));
    chk({req, " vld"},  64'(out_vld_o), 64'd1);
    chk({req, " port"}, 64'(out_port_o), 64'(p));
    chk({req, " sop"},  64'(out_sop_o), 64'(s));
    chk({req, " eop"},  64'(out_eop_o), 64'(e));
    chk({req, " cnt"},  64'(out_cnt_o), 64'(nb));
    chk({req, " err"},  64'(out_err_o), 64'(er));
    chk({req, " dat"},  64'(out_dat_o), 64'(d & mask));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sel_i = 0; en_n_i = 1; sop_i = 0; eop_i = 0; mod_i = 0; err_i = 0;
    par_i = 1; dat_i = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 vld in reset", 64'(out_vld_o), 64'd0);
    chk("R1 par in reset", 64'(par_err_o), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle();
    chk("R1 vld idle", 64'(out_vld_o), 64'd0);
    chk("R1 proto idle", 64'(proto_err_o), 64'd0);
    chk("R1 par idle", 64'(par_err_o), 64'd0);

    // sweep every port against every modulo value
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] base;
        base = 32'hA1B2_C3D4 ^ {p[7:0], m[7:0], p[7:0] ^ 8'h5A, m[7:0] ^ 8'h3C};
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, {30'h2AAA_5555, p[1:0]}, 1'b0);
        chk("R2 select silent", 64'({out_vld_o, proto_err_o}), 64'd0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1, base, 1'b0);
        expect_word("R3 first word", p[1:0], 1'b1, 1'b0, 4, 1'b0, base);
        idle();
        chk("R4 pause no word", 64'(out_vld_o), 64'd0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, m[1:0], 1'b1, ~base, 1'b0);
        expect_word("R8 R9 R4 mid word", p[1:0], 1'b0, 1'b0, 4, 1'b0, ~base);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, m[1:0], m[0], base + 32'h0101_0101, 1'b0);
        expect_word("R6 R7 R9 final word", p[1:0], 1'b0, 1'b1, 4 - m, m[0],
                    base + 32'h0101_0101);
      end
    end

    // packet is closed on port 3: a word without start is dropped
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 32'hDEAD_BEEF, 1'b0);
    chk("R5 drop vld", 64'(out_vld_o), 64'd0);
    chk("R5 drop proto", 64'(proto_err_o), 64'd1);
    idle();
    chk("R5 proto pulse ends", 64'(proto_err_o), 64'd0);
    // single-word packet closes at once
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 32'h1234_5678, 1'b0);
    expect_word("R6 single word", 2'd3, 1'b1, 1'b1, 2, 1'b0, 32'h1234_5678);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 32'h1111_2222, 1'b0);
    chk("R5 after single proto", 64'(proto_err_o), 64'd1);

    // interleaved ports
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 32'hAAAA_0000, 1'b0);
    expect_word("R11 port0 start", 2'd0, 1'b1, 1'b0, 4, 1'b0, 32'hAAAA_0000);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 32'hBBBB_0001, 1'b0);
    expect_word("R11 port1 start", 2'd1, 1'b1, 1'b0, 4, 1'b0, 32'hBBBB_0001);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 32'hAAAA_0002, 1'b0);
    expect_word("R11 port0 resume", 2'd0, 1'b0, 1'b1, 3, 1'b1, 32'hAAAA_0002);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 32'hBBBB_0003, 1'b0);
    expect_word("R11 port1 resume", 2'd1, 1'b0, 1'b1, 1, 1'b0, 32'hBBBB_0003);
    chk("R10 no parity error yet", 64'(par_err_o), 64'd0);

    // parity
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0F0F_0F0F, 1'b1);
    chk("R10 paused cycle unchecked", 64'(par_err_o), 64'(exp_par));
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h2, 1'b1);
    exp_par[2] = 1'b1;
    chk("R10 select parity port2", 64'(par_err_o), 64'(exp_par));
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h1, 1'b0);
    chk("R10 good select", 64'(par_err_o), 64'(exp_par));
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 32'h7777_1234, 1'b1);
    exp_par[1] = 1'b1;
    chk("R10 data parity port1", 64'(par_err_o), 64'(exp_par));
    repeat (3) idle();
    chk("R10 sticky", 64'(par_err_o), 64'(exp_par));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule